// File: doc/BRIEF.md
# Multi-Mode Synchronous Serial Transmitter

This block is the transmit half of one synchronous serial channel. It takes bytes from a small write buffer and shifts them onto a single serial line, least significant bit first. One bit leaves for each pulse of a bit-rate clock enable. The line never stops. When the buffer has nothing to send, the transmitter fills the gap with sync characters or flags, depending on the framing mode chosen.

Three framings share one 16-bit shift register. That register loads from the buffer, from the low sync register, or from the high sync register. In monosync the idle character comes from the low register and is either 6 or 8 bits wide. In bisync the idle pattern is 16 bits, with the low register sent first. In bit-oriented mode the high register holds the flag value, normally 0x7E. A frame opens with a flag and carries the buffered bytes. It closes by itself when the buffer runs dry at a byte boundary, ending with a 16-bit check sequence and a flag. Zero insertion keeps data from ever looking like a flag. An optional NRZI stage re-codes the stream just before the pin.

Top module: `sync_tx_top`

## Requirements
- R1: Each accepted byte is sent whole, in write order, least significant bit first, at one bit per cycle in which `bit_en` is high. `txd` changes only after a cycle with `bit_en` high.
- R2: With `mode` = 0 and `sync6` low, an empty buffer at a character boundary makes the transmitter send the 8 bits of `sync_lo`, LSB first.
- R3: With `mode` = 0 and `sync6` high, the idle character is `sync_lo[5:0]`, 6 bits long, LSB first. Data bytes are still 8 bits.
- R4: With `mode` = 1, the idle pattern is 16 bits: `sync_lo` first, then `sync_hi`, each LSB first.
- R5: With `mode` = 2, the idle line carries back-to-back copies of `sync_hi`, the flag. Every frame starts and ends with a flag.
- R6: In `mode` 2, a 0 is inserted after any five consecutive 1s in data or check-sequence bits. No 0 is inserted inside a flag, and the run of ones is cleared by flag bits.
- R7: A frame's check sequence is CRC-16 over its data bits. The register shifts right with reflected polynomial 0x8408 (x^16+x^12+x^5+1) and is preset to 0xFFFF. The ones-complement of the final value is sent LSB first, right before the closing flag.
- R8: With `nrzi_en` high, a 0 bit toggles `txd` and a 1 bit leaves it unchanged. With `nrzi_en` low, `txd` equals the bit.
- R9: A write is accepted only while `wr_ready` is high (buffer not full). A write while full is dropped and leaves the buffer unchanged. `buf_empty` is high when no byte is waiting.
- R10: During and right after reset, `txd` is 1, `buf_empty` is 1 and `wr_ready` is 1.
- R11: In `mode` 2, a frame stays open as long as bytes are waiting at each byte boundary and closes at the first boundary where the buffer is empty. A new frame opens only after at least one flag has been sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per high cycle |
| wr_valid | input | 1 | Write strobe for the data buffer |
| wr_data | input | 8 | Byte to queue |
| wr_ready | output | 1 | Buffer can take a byte |
| buf_empty | output | 1 | Buffer holds no byte |
| mode | input | 2 | 0 monosync, 1 bisync, 2 bit-oriented (3 acts as 0) |
| sync6 | input | 1 | Monosync idle character is 6 bits wide |
| sync_lo | input | 8 | Low sync register |
| sync_hi | input | 8 | High sync register / flag value |
| nrzi_en | input | 1 | Select NRZI line coding |
| txd | output | 1 | Serial output |

## Verification
The bench builds the block with `BUF_DEPTH` = 4, while the default is 1. With four entries, a few writes made while the bit clock is stopped fill the buffer, so the full and dropped-write path is reached. The same depth lets the driver keep several bytes queued, which keeps a multi-byte frame open without underrun. A monitor recovers bits from the line, undoing NRZI and zero insertion. It parses sync tokens or flag-delimited frames and compares bytes, lengths and check sequences with the scoreboard. Data patterns such as 0xFF and 0x3F force insertion in data, and 0xFF also gives runs of ones in the check sequence.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

    typedef enum logic [1:0] {
        MODE_MONO   = 2'd0,
        MODE_BISYNC = 2'd1,
        MODE_HDLC   = 2'd2
    } tx_mode_e;

    typedef enum logic [1:0] {
        CH_SYNC = 2'd0,
        CH_DATA = 2'd1,
        CH_FCS  = 2'd2,
        CH_FLAG = 2'd3
    } chunk_e;

    localparam int SHIFT_W = 16;
    localparam int CNT_W   = $clog2(SHIFT_W + 1);
    localparam int RUN_W   = 3;

    typedef struct packed {
        logic [SHIFT_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        chunk_e             kind;
        logic [RUN_W-1:0]   ones;
        logic               in_frame;
    } ser_state_t;

    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_PRESET    = 16'hFFFF;

endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int MEM = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] count;
    } fifo_state_t;

    fifo_state_t   f_d, f_q;
    logic [DW-1:0] mem [MEM];
    logic          full, push, pop;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (f_q.count == CW'(DEPTH));
    assign empty    = (f_q.count == '0);
    assign wr_ready = !full;
    assign push     = wr_valid && !full;
    assign pop      = rd_en && !empty;
    assign rd_data  = mem[f_q.rp];

    always_comb begin
        f_d = f_q;
        if (push) f_d.wp = step_ptr(f_q.wp);
        if (pop)  f_d.rp = step_ptr(f_q.rp);
        case ({push, pop})
            2'b10:   f_d.count = f_q.count + CW'(1);
            2'b01:   f_d.count = f_q.count - CW'(1);
            default: f_d.count = f_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
        if (push) mem[f_q.wp] <= wr_data;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !rd_en) |=> $stable(f_q.count));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.count <= CW'(DEPTH));

endmodule

// File: rtl/tx_crc16.sv
module tx_crc16
    import sync_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        step,
    input  logic        din,
    output logic [15:0] crc
);
    logic [15:0] crc_d, crc_q, base;
    logic        fb;

    always_comb begin
        base  = init ? CRC_PRESET : crc_q;
        fb    = base[0] ^ din;
        crc_d = base;
        if (step) crc_d = {1'b0, base[15:1]} ^ (fb ? CRC_POLY_REFL : 16'h0000);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= CRC_PRESET;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    assert_crc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !step) |=> $stable(crc_q));

endmodule

// File: rtl/tx_nrzi.sv
module tx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic nrzi_en,
    input  logic din,
    output logic txd
);
    logic txd_d, txd_q;

    always_comb begin
        txd_d = txd_q;
        if (en) txd_d = nrzi_en ? (din ? txd_q : ~txd_q) : din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= txd_d;
    end

    assign txd = txd_q;

    assert_nrzi_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && nrzi_en && !din) |=> (txd_q != $past(txd_q)));

    assert_nrzi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && nrzi_en && din) |=> $stable(txd_q));

endmodule

// File: rtl/sync_tx_top.sv
module sync_tx_top
    import sync_tx_pkg::*;
#(
    parameter int BUF_DEPTH = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    output logic       buf_empty,
    input  logic [1:0] mode,
    input  logic       sync6,
    input  logic [7:0] sync_lo,
    input  logic [7:0] sync_hi,
    input  logic       nrzi_en,
    output logic       txd
);
    localparam logic [CNT_W-1:0] LEN_BYTE = CNT_W'(8);
    localparam logic [CNT_W-1:0] LEN_SIX  = CNT_W'(6);
    localparam logic [CNT_W-1:0] LEN_WORD = CNT_W'(16);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(5);

    ser_state_t  s_d, s_q, eff;
    logic        pop, crc_init, crc_step, ser_bit, stuff;
    logic        fifo_empty;
    logic [7:0]  fifo_data;
    logic [15:0] crc_val;
    logic        is_hdlc, is_bisync;

    assign is_hdlc   = (mode == MODE_HDLC);
    assign is_bisync = (mode == MODE_BISYNC);
    assign buf_empty = fifo_empty;

    tx_fifo #(.DW(8), .DEPTH(BUF_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_en(pop), .rd_data(fifo_data), .empty(fifo_empty)
    );

    tx_crc16 u_crc (
        .clk(clk), .rst_n(rst_n),
        .init(crc_init), .step(crc_step), .din(ser_bit), .crc(crc_val)
    );

    tx_nrzi u_line (
        .clk(clk), .rst_n(rst_n),
        .en(bit_en), .nrzi_en(nrzi_en), .din(ser_bit), .txd(txd)
    );

    always_comb begin
        eff      = s_q;
        s_d      = s_q;
        pop      = 1'b0;
        crc_init = 1'b0;
        crc_step = 1'b0;
        ser_bit  = 1'b1;
        stuff    = 1'b0;
        if (bit_en) begin
            // pick the next character when the previous one is used up
            if (s_q.cnt == '0) begin
                if (is_hdlc) begin
                    if (s_q.in_frame && !fifo_empty) begin
                        eff.sh   = {8'h00, fifo_data};
                        eff.cnt  = LEN_BYTE;
                        eff.kind = CH_DATA;
                        pop      = 1'b1;
                    end else if (s_q.in_frame) begin
                        eff.sh       = ~crc_val;
                        eff.cnt      = LEN_WORD;
                        eff.kind     = CH_FCS;
                        eff.in_frame = 1'b0;
                    end else if (!fifo_empty && s_q.kind == CH_FLAG) begin
                        eff.sh       = {8'h00, fifo_data};
                        eff.cnt      = LEN_BYTE;
                        eff.kind     = CH_DATA;
                        eff.in_frame = 1'b1;
                        pop          = 1'b1;
                        crc_init     = 1'b1;
                    end else begin
                        eff.sh   = {8'h00, sync_hi};
                        eff.cnt  = LEN_BYTE;
                        eff.kind = CH_FLAG;
                    end
                end else if (!fifo_empty) begin
                    eff.sh   = {8'h00, fifo_data};
                    eff.cnt  = LEN_BYTE;
                    eff.kind = CH_DATA;
                    pop      = 1'b1;
                end else if (is_bisync) begin
                    eff.sh   = {sync_hi, sync_lo};
                    eff.cnt  = LEN_WORD;
                    eff.kind = CH_SYNC;
                end else begin
                    eff.sh   = {8'h00, sync_lo};
                    eff.cnt  = sync6 ? LEN_SIX : LEN_BYTE;
                    eff.kind = CH_SYNC;
                end
            end
            stuff = is_hdlc && (eff.ones == RUN_MAX);
            s_d   = eff;
            if (stuff) begin
                ser_bit  = 1'b0;
                s_d.ones = '0;
            end else begin
                ser_bit  = eff.sh[0];
                s_d.sh   = {1'b0, eff.sh[SHIFT_W-1:1]};
                s_d.cnt  = eff.cnt - CNT_W'(1);
                crc_step = (eff.kind == CH_DATA);
                if (is_hdlc && (eff.kind == CH_DATA || eff.kind == CH_FCS))
                    s_d.ones = ser_bit ? eff.ones + RUN_W'(1) : '0;
                else
                    s_d.ones = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sh       <= '0;
            s_q.cnt      <= '0;
            s_q.kind     <= CH_SYNC;
            s_q.ones     <= '0;
            s_q.in_frame <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ones <= RUN_MAX);

    assert_open_after_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.in_frame) |-> ($past(s_q.kind) == CH_FLAG));

    assert_line_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(txd));

    assert_fcs_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kind == CH_FCS) |-> !s_q.in_frame);

endmodule

// File: tb/tb_sync_tx_top.sv
module tb_sync_tx_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ready, buf_empty, txd;
    logic [1:0] mode = 2'd0;
    logic       sync6 = 1'b0;
    logic [7:0] sync_lo = 8'h16;
    logic [7:0] sync_hi = 8'h7E;
    logic       nrzi_en = 1'b0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  bit_run = 0;
    int  div = 0;

    logic [7:0] exp_q[$];
    int         flen_q[$];

    // monitor state
    logic       prev_lvl;
    logic [15:0] acc;
    int         nacc;
    int         syncs_seen, flags_seen, frames_seen;
    int         hones;
    bit         fb [0:1023];
    int         fbn;

    sync_tx_top #(.BUF_DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .buf_empty(buf_empty), .mode(mode), .sync6(sync6),
        .sync_lo(sync_lo), .sync_hi(sync_hi), .nrzi_en(nrzi_en), .txd(txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_of(input logic [7:0] b [$]);
        logic [15:0] c = 16'hFFFF;
        foreach (b[k]) begin
            for (int j = 0; j < 8; j++) begin
                logic f = c[0] ^ b[k][j];
                c = {1'b0, c[15:1]} ^ (f ? 16'h8408 : 16'h0000);
            end
        end
        return c;
    endfunction

    task automatic data_token(input logic [7:0] v);
        if (exp_q.size() == 0) begin
            check(0, "R1 unexpected byte", v, 0);
        end else begin
            logic [7:0] e = exp_q.pop_front();
            check(v == e, "R1 byte order", v, e);
        end
    endtask

    task automatic sync_bit(input logic b);
        acc[nacc] = b;
        nacc++;
        if (mode == 2'd1) begin
            if (nacc == 8 && acc[7:0] != sync_lo) begin
                data_token(acc[7:0]); nacc = 0;
            end else if (nacc == 16) begin
                check(acc[15:8] == sync_hi, "R4 bisync high half", acc[15:8], sync_hi);
                syncs_seen++; nacc = 0;
            end
        end else if (sync6) begin
            if (nacc == 6 && acc[5:0] == sync_lo[5:0]) begin
                syncs_seen++; nacc = 0;
            end else if (nacc == 8) begin
                data_token(acc[7:0]); nacc = 0;
            end
        end else if (nacc == 8) begin
            if (acc[7:0] == sync_lo) syncs_seen++;
            else data_token(acc[7:0]);
            nacc = 0;
        end
    endtask

    task automatic hdlc_frame();
        int nb = fbn / 8;
        frames_seen++;
        if ((fbn % 8) != 0 || nb < 3) begin
            check(0, "R6 frame bit count", fbn, nb * 8);
        end else begin
            logic [7:0] bytes [$];
            logic [7:0] dbytes [$];
            logic [15:0] fcs, c;
            for (int k = 0; k < nb; k++) begin
                logic [7:0] v;
                for (int j = 0; j < 8; j++) v[j] = fb[8*k + j];
                bytes.push_back(v);
            end
            for (int k = 0; k < nb - 2; k++) dbytes.push_back(bytes[k]);
            fcs = {bytes[nb-1], bytes[nb-2]};
            c = crc_of(dbytes);
            check(fcs == ~c, "R7 check sequence", fcs, ~c);
            if (flen_q.size() == 0) begin
                check(0, "R11 unexpected frame", nb - 2, 0);
            end else begin
                int el = flen_q.pop_front();
                check(nb - 2 == el, "R11 frame length", nb - 2, el);
            end
            foreach (dbytes[k]) data_token(dbytes[k]);
        end
    endtask

    task automatic hdlc_bit(input logic b);
        if (b) begin
            hones++;
            if (hones >= 7) begin
                check(0, "R6 run of ones", hones, 6);
                hones = 0; fbn = 0;
            end else if (fbn < 1024) begin
                fb[fbn] = 1'b1; fbn++;
            end
        end else begin
            if (hones == 5) begin
                // inserted zero, dropped
            end else if (hones == 6) begin
                fbn = fbn - 7;
                if (fbn > 0) hdlc_frame();
                flags_seen++;
                fbn = 0;
            end else if (fbn < 1024) begin
                fb[fbn] = 1'b0; fbn++;
            end
            hones = 0;
        end
    endtask

    // bit-enable generator and line monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_lvl = 1'b1; nacc = 0; acc = '0; hones = 0; fbn = 0;
            syncs_seen = 0; flags_seen = 0; frames_seen = 0;
            div = 0; bit_en = 1'b0;
        end else begin
            if (bit_en) begin
                logic b;
                b = nrzi_en ? (txd == prev_lvl) : txd;
                prev_lvl = txd;
                if (mode == 2'd2) hdlc_bit(b);
                else sync_bit(b);
            end
            if (bit_run) begin
                div = (div + 1) % DIV;
                bit_en = (div == DIV - 1);
            end else begin
                bit_en = 1'b0;
            end
        end
    end

    task automatic send_byte(input logic [7:0] v);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_data = v;
        exp_q.push_back(v);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] v [$]);
        foreach (v[k]) send_byte(v[k]);
        flen_q.push_back(v.size());
    endtask

    task automatic wait_bits(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] m, input logic s6, input logic [7:0] lo,
                         input logic [7:0] hi, input logic nz, input bit run);
        rst_n = 1'b0; bit_run = 0; wr_valid = 1'b0;
        exp_q.delete(); flen_q.delete();
        mode = m; sync6 = s6; sync_lo = lo; sync_hi = hi; nrzi_en = nz;
        repeat (4) @(negedge clk);
        check(txd == 1'b1, "R10 txd in reset", txd, 1);
        rst_n = 1'b1;
        @(negedge clk);
        bit_run = run;
    endtask

    task automatic finish_test(input string req);
        check(exp_q.size() == 0, "R1 bytes left unsent", exp_q.size(), 0);
        check(buf_empty == 1'b1, "R9 buffer drained", buf_empty, 1);
    endtask

    initial begin
        logic [7:0] fr [$];
        // reset state
        start(2'd0, 1'b0, 8'h16, 8'h7E, 1'b0, 0);
        check(txd == 1'b1, "R10 txd after reset", txd, 1);
        check(buf_empty == 1'b1, "R10 buffer empty", buf_empty, 1);
        check(wr_ready == 1'b1, "R10 write ready", wr_ready, 1);

        // monosync, 8-bit idle
        bit_run = 1;
        wait_bits(20);
        send_byte(8'hA5); send_byte(8'h01); send_byte(8'hFF); send_byte(8'h80);
        wait_bits(80);
        check(syncs_seen > 2, "R2 8-bit sync idle", syncs_seen, 3);
        finish_test("R1");

        // monosync, 6-bit idle
        start(2'd0, 1'b1, 8'h2B, 8'h00, 1'b0, 1);
        wait_bits(15);
        send_byte(8'h55); send_byte(8'hC3); send_byte(8'h00);
        wait_bits(60);
        check(syncs_seen > 2, "R3 6-bit sync idle", syncs_seen, 3);
        finish_test("R3");

        // bisync
        start(2'd1, 1'b0, 8'h32, 8'h4C, 1'b0, 1);
        wait_bits(40);
        send_byte(8'h12); send_byte(8'hFE); send_byte(8'h4C);
        wait_bits(80);
        check(syncs_seen > 2, "R4 16-bit sync idle", syncs_seen, 3);
        finish_test("R4");

        // full buffer, dropped write
        start(2'd0, 1'b0, 8'h16, 8'h7E, 1'b0, 0);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        check(wr_ready == 1'b0, "R9 ready low when full", wr_ready, 0);
        check(buf_empty == 1'b0, "R9 buffer not empty", buf_empty, 0);
        wr_valid = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        wr_valid = 1'b0;
        bit_run = 1;
        wait_bits(80);
        finish_test("R9");

        // bit-oriented, plain line coding
        start(2'd2, 1'b0, 8'h00, 8'h7E, 1'b0, 1);
        wait_bits(20);
        fr = '{8'hFF, 8'h7E, 8'h3F, 8'h01};
        send_frame(fr);
        wait_bits(100);
        fr = '{8'h5A};
        send_frame(fr);
        wait_bits(80);
        check(frames_seen == 2, "R11 frame count", frames_seen, 2);
        check(flags_seen > 4, "R5 flags on idle line", flags_seen, 5);
        check(flen_q.size() == 0, "R11 frames missing", flen_q.size(), 0);
        finish_test("R5");

        // bit-oriented with NRZI
        start(2'd2, 1'b0, 8'h00, 8'h7E, 1'b1, 1);
        wait_bits(20);
        fr = '{8'h00, 8'h81, 8'hFF};
        send_frame(fr);
        wait_bits(100);
        check(frames_seen == 1, "R8 frame through NRZI", frames_seen, 1);
        check(flags_seen > 2, "R8 flags through NRZI", flags_seen, 3);
        finish_test("R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule